// File: doc/BRIEF.md
# Banked Host Address Translator

This block sits between the host bus and video memory. A CPU access that falls in the legacy graphics aperture at A0000h–BFFFFh becomes a 20-bit linear video-memory address. When the extended-memory mode is on, one of two 16-bit bank offsets is added to the access. Each offset counts in 16-byte units. A primary offset and a secondary offset are held. A three-bit mode field chooses between them by access direction or by sub-window. The same path also relocates the display fetch address by a third offset, which is used for panning and page flipping.

Configuration goes through an index/data write port. A key register gates it. Bit 0 of the key opens the extended registers. Bit 1 opens the memory-organisation field, which is a separate guard on its own. The translation itself is combinational from the registered configuration, so an access is translated in the cycle it is presented.

Top module: `bank_xlate`

## Requirements
- R1: After a synchronous reset, every register is zero. An access at A0000h–AFFFFh then hits and maps to its address minus A0000h. `dram_cfg` reads 0 and `disp_addr_out` equals `disp_addr_in`.
- R2: A write to any index 10h–17h is ignored while key bit 0 is clear. The key register is index 00h. It holds bit 0 (extended-register open) and bit 1 (memory-organisation open), and it is always writable.
- R3: Index 16h bits [1:0] drive `dram_cfg`. They change only when key bit 1 is set. The rest of that write still takes effect. Index 16h layout: [2] secondary-read enable, [3] display-offset enable, [4] extended-memory enable, [7:5] mode.
- R4: In the non-banked modes the window comes from index 17h, where [0] is the bit-16 add and [2:1] is the map select. Map 0 with bit-16 add covers A0000h–BFFFFh as one 128K window. Map 0 without it, and map 1, cover A0000h–AFFFFh. Map 2 covers B0000h–B7FFFh and map 3 covers B8000h–BFFFFh. The local address is the access address minus the window base.
- R5: An access outside the active window gives `hit`=0 and `mem_addr`=0.
- R6: With extended memory off, no offset is added: `mem_addr` equals the local address.
- R7: With extended memory on, `mem_addr` = local + 16 × selected offset, modulo 2^20. Primary offset: index 10h high, 11h low. Secondary offset: 12h high, 13h low.
- R8: Modes 0, 1, 4, 5 and 7 send writes (`host_wr`=1) to the primary offset. Reads go to the secondary offset when secondary-read enable is set, and to the primary otherwise.
- R9: Mode 3 uses the secondary offset for every read and write.
- R10: Mode 2 hits A0000h–BFFFFh. The A0000h segment uses the primary offset and the B0000h segment uses the secondary. The local address is the address minus its segment base.
- R11: Mode 6 hits A0000h–AFFFFh only. A0000h–A7FFFh uses the primary offset and A8000h–AFFFFh uses the secondary. The local address is the address minus its 32K half base.
- R12: `disp_addr_out` = `disp_addr_in` + 16 × display offset, modulo 2^20, when both display-offset enable and extended memory are set. Otherwise it equals `disp_addr_in`. Display offset: index 14h high, 15h low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Register write data |
| host_addr | input | 20 | Host memory address |
| host_wr | input | 1 | 1 = write access, 0 = read |
| disp_addr_in | input | 20 | Untranslated display fetch address |
| hit | output | 1 | Access falls in the active window |
| mem_addr | output | 20 | Translated video-memory address |
| disp_addr_out | output | 20 | Relocated display fetch address |
| dram_cfg | output | 2 | Protected memory-organisation field |

## Verification
Two functions can be active in the same cycle: a host translation and a display relocation. Both read the extended-memory bit, and a register write can change that bit or an offset on the very edge that precedes the access. The bench interleaves random register writes with host accesses and display addresses, and compares every translation against a shadow model of the register state. The model is updated under the same lock rules. This shows that a change to a shared control bit moves both outputs together, that a blocked write moves neither, and that each output draws only on its own offset.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
    localparam int HOST_AW   = 20;
    localparam int OFF_W     = 16;
    localparam int OFF_SHIFT = 4;
    localparam int REG_W     = 8;
    localparam int LOCAL_W   = 17;

    localparam logic [REG_W-1:0] IDX_KEY    = 8'h00;
    localparam logic [REG_W-1:0] IDX_PRI_HI = 8'h10;
    localparam logic [REG_W-1:0] IDX_PRI_LO = 8'h11;
    localparam logic [REG_W-1:0] IDX_SEC_HI = 8'h12;
    localparam logic [REG_W-1:0] IDX_SEC_LO = 8'h13;
    localparam logic [REG_W-1:0] IDX_DSP_HI = 8'h14;
    localparam logic [REG_W-1:0] IDX_DSP_LO = 8'h15;
    localparam logic [REG_W-1:0] IDX_MEMCTL = 8'h16;
    localparam logic [REG_W-1:0] IDX_WINCTL = 8'h17;

    localparam logic [2:0] MODE_DUAL64   = 3'd2;
    localparam logic [2:0] MODE_SEC_ONLY = 3'd3;
    localparam logic [2:0] MODE_HALF32   = 3'd6;

    localparam logic [3:0] SEG_A = 4'hA;
    localparam logic [3:0] SEG_B = 4'hB;

    typedef enum logic [1:0] {
        MAP_WIDE   = 2'd0,
        MAP_A64    = 2'd1,
        MAP_B32_LO = 2'd2,
        MAP_B32_HI = 2'd3
    } map_sel_t;

    typedef struct packed {
        logic [OFF_W-1:0] pri_off;
        logic [OFF_W-1:0] sec_off;
        logic [OFF_W-1:0] dsp_off;
        logic [1:0]       dram_cfg;
        logic             sec_en;
        logic             dsp_en;
        logic             ext_en;
        logic [2:0]       mode;
        logic             b16_add;
        map_sel_t         map;
    } cfg_t;

    typedef struct packed {
        logic               hit;
        logic               sec;
        logic [LOCAL_W-1:0] local_addr;
    } win_t;

    function automatic logic default_pick_sec(input logic [2:0] mode,
                                              input logic wr,
                                              input logic sec_en);
        return (mode == MODE_SEC_ONLY) || (!wr && sec_en);
    endfunction
endpackage

// File: rtl/hbx_regs.sv
module hbx_regs
    import hbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_idx,
    input  logic [REG_W-1:0] cfg_wdata,
    output cfg_t             cfg
);
    logic [1:0] key;

    always_ff @(posedge clk) begin
        if (rst) begin
            key <= '0;
            cfg <= '0;
        end else if (cfg_we) begin
            if (cfg_idx == IDX_KEY) begin
                key <= cfg_wdata[1:0];
            end else if (key[0]) begin
                case (cfg_idx)
                    IDX_PRI_HI: cfg.pri_off[15:8] <= cfg_wdata;
                    IDX_PRI_LO: cfg.pri_off[7:0]  <= cfg_wdata;
                    IDX_SEC_HI: cfg.sec_off[15:8] <= cfg_wdata;
                    IDX_SEC_LO: cfg.sec_off[7:0]  <= cfg_wdata;
                    IDX_DSP_HI: cfg.dsp_off[15:8] <= cfg_wdata;
                    IDX_DSP_LO: cfg.dsp_off[7:0]  <= cfg_wdata;
                    IDX_MEMCTL: begin
                        cfg.sec_en <= cfg_wdata[2];
                        cfg.dsp_en <= cfg_wdata[3];
                        cfg.ext_en <= cfg_wdata[4];
                        cfg.mode   <= cfg_wdata[7:5];
                        if (key[1]) cfg.dram_cfg <= cfg_wdata[1:0];
                    end
                    IDX_WINCTL: begin
                        cfg.b16_add <= cfg_wdata[0];
                        cfg.map     <= map_sel_t'(cfg_wdata[2:1]);
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    ext_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !key[0] && cfg_idx != IDX_KEY) |=> $stable(cfg));

    // R3
    dram_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !key[1]) |=> $stable(cfg.dram_cfg));
endmodule

// File: rtl/hbx_window.sv
module hbx_window
    import hbx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  cfg_t               cfg,
    output win_t               win
);
    logic [3:0] seg;
    logic       in_a, in_b;

    assign seg  = host_addr[HOST_AW-1:HOST_AW-4];
    assign in_a = (seg == SEG_A);
    assign in_b = (seg == SEG_B);

    always_comb begin
        win = '0;
        if (cfg.ext_en && cfg.mode == MODE_DUAL64) begin
            win.hit        = in_a || in_b;
            win.sec        = in_b;
            win.local_addr = LOCAL_W'(host_addr[15:0]);
        end else if (cfg.ext_en && cfg.mode == MODE_HALF32) begin
            win.hit        = in_a;
            win.sec        = host_addr[15];
            win.local_addr = LOCAL_W'(host_addr[14:0]);
        end else begin
            win.sec = default_pick_sec(cfg.mode, host_wr, cfg.sec_en);
            unique case (cfg.map)
                MAP_WIDE: begin
                    if (cfg.b16_add) begin
                        win.hit        = in_a || in_b;
                        win.local_addr = host_addr[16:0];
                    end else begin
                        win.hit        = in_a;
                        win.local_addr = LOCAL_W'(host_addr[15:0]);
                    end
                end
                MAP_A64: begin
                    win.hit        = in_a;
                    win.local_addr = LOCAL_W'(host_addr[15:0]);
                end
                MAP_B32_LO: begin
                    win.hit        = in_b && !host_addr[15];
                    win.local_addr = LOCAL_W'(host_addr[14:0]);
                end
                MAP_B32_HI: begin
                    win.hit        = in_b && host_addr[15];
                    win.local_addr = LOCAL_W'(host_addr[14:0]);
                end
            endcase
        end
    end

    // R4
    window_range_chk: assert property (@(posedge clk) disable iff (rst)
        win.hit |-> (host_addr[HOST_AW-1:HOST_AW-3] == 3'b101));

    // R9
    sec_only_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.ext_en && cfg.mode == MODE_SEC_ONLY && win.hit) |-> win.sec);

    // R11
    half32_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.ext_en && cfg.mode == MODE_HALF32 && win.hit) |-> in_a);
endmodule

// File: rtl/hbx_offset_add.sv
module hbx_offset_add #(
    parameter int AW    = 20,
    parameter int OW    = 16,
    parameter int SHIFT = 4
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] off,
    input  logic          en,
    output logic [AW-1:0] sum
);
    localparam int SW = OW + SHIFT;

    logic [SW-1:0] wide;
    logic [AW-1:0] scaled;

    assign wide = {off, {SHIFT{1'b0}}};

    generate
        if (SW >= AW) begin : g_trunc
            assign scaled = wide[AW-1:0];
        end else begin : g_extend
            assign scaled = {{(AW-SW){1'b0}}, wide};
        end
    endgenerate

    assign sum = en ? (base + scaled) : base;
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
    import hbx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_idx,
    input  logic [7:0]         cfg_wdata,
    input  logic [19:0]        host_addr,
    input  logic               host_wr,
    input  logic [19:0]        disp_addr_in,
    output logic               hit,
    output logic [19:0]        mem_addr,
    output logic [19:0]        disp_addr_out,
    output logic [1:0]         dram_cfg
);
    cfg_t               cfg;
    win_t               win;
    logic [HOST_AW-1:0] host_sum;
    logic [OFF_W-1:0]   host_off;

    hbx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    hbx_window u_win (
        .clk       (clk),
        .rst       (rst),
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .cfg       (cfg),
        .win       (win)
    );

    assign host_off = win.sec ? cfg.sec_off : cfg.pri_off;

    hbx_offset_add #(.AW(HOST_AW), .OW(OFF_W), .SHIFT(OFF_SHIFT)) u_host_add (
        .base (HOST_AW'(win.local_addr)),
        .off  (host_off),
        .en   (cfg.ext_en),
        .sum  (host_sum)
    );

    hbx_offset_add #(.AW(HOST_AW), .OW(OFF_W), .SHIFT(OFF_SHIFT)) u_disp_add (
        .base (disp_addr_in),
        .off  (cfg.dsp_off),
        .en   (cfg.ext_en && cfg.dsp_en),
        .sum  (disp_addr_out)
    );

    assign hit      = win.hit;
    assign mem_addr = win.hit ? host_sum : '0;
    assign dram_cfg = cfg.dram_cfg;

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (mem_addr == '0));

    // R6
    no_ext_local_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.ext_en && hit) |-> (mem_addr[HOST_AW-1:LOCAL_W] == '0));

    // R12
    disp_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg.ext_en && cfg.dsp_en) |-> (disp_addr_out == disp_addr_in));
endmodule

// File: tb/bank_xlate_bench.sv
module bank_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [19:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic [19:0] disp_addr_in = '0;
    logic        hit;
    logic [19:0] mem_addr;
    logic [19:0] disp_addr_out;
    logic [1:0]  dram_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // shadow of the register state, kept by the requirement rules
    logic [1:0]  m_key = '0;
    logic [15:0] m_pri = '0, m_sec = '0, m_dsp = '0;
    logic [7:0]  m_ctl = '0, m_win = '0;

    always #10 clk = ~clk;

    bank_xlate u_bank_xlate (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .host_addr(host_addr), .host_wr(host_wr),
        .disp_addr_in(disp_addr_in), .hit(hit), .mem_addr(mem_addr),
        .disp_addr_out(disp_addr_out), .dram_cfg(dram_cfg)
    );

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx == 8'h00) m_key = d[1:0];
        else if (m_key[0]) begin
            case (idx)
                8'h10: m_pri[15:8] = d;
                8'h11: m_pri[7:0]  = d;
                8'h12: m_sec[15:8] = d;
                8'h13: m_sec[7:0]  = d;
                8'h14: m_dsp[15:8] = d;
                8'h15: m_dsp[7:0]  = d;
                8'h16: begin
                    m_ctl[7:2] = d[7:2];
                    if (m_key[1]) m_ctl[1:0] = d[1:0];
                end
                8'h17: m_win = d;
                default: ;
            endcase
        end
    endtask

    // returns {hit, address}
    function automatic logic [20:0] model(input logic [19:0] a, input logic w);
        logic ext;
        logic [2:0] mode;
        logic h, sec;
        logic [19:0] base, lo, hi, loc, off;
        ext = m_ctl[4];
        mode = m_ctl[7:5];
        if (ext && mode == 3'd2) begin
            lo = 20'hA0000; hi = 20'hBFFFF;
            base = (a < 20'hB0000) ? 20'hA0000 : 20'hB0000;
            sec = (a >= 20'hB0000);
        end else if (ext && mode == 3'd6) begin
            lo = 20'hA0000; hi = 20'hAFFFF;
            base = (a < 20'hA8000) ? 20'hA0000 : 20'hA8000;
            sec = (a >= 20'hA8000);
        end else begin
            sec = (mode == 3'd3) || (!w && m_ctl[2]);
            case (m_win[2:1])
                2'd0: begin lo = 20'hA0000; hi = m_win[0] ? 20'hBFFFF : 20'hAFFFF; end
                2'd1: begin lo = 20'hA0000; hi = 20'hAFFFF; end
                2'd2: begin lo = 20'hB0000; hi = 20'hB7FFF; end
                default: begin lo = 20'hB8000; hi = 20'hBFFFF; end
            endcase
            base = lo;
        end
        h = (a >= lo) && (a <= hi);
        if (!h) return 21'd0;
        loc = a - base;
        off = {sec ? m_sec : m_pri, 4'h0};
        return {1'b1, ext ? loc + off : loc};
    endfunction

    task automatic acc(input string tag, input logic [19:0] a, input logic w);
        logic [20:0] e;
        @(negedge clk);
        host_addr = a; host_wr = w;
        #2;
        e = model(a, w);
        checks++;
        if ({hit, mem_addr} !== e) begin
            errors++;
            $display("FAIL %s addr=%h wr=%0b actual hit=%0b mem=%h expected hit=%0b mem=%h",
                     tag, a, w, hit, mem_addr, e[20], e[19:0]);
        end
    endtask

    task automatic dsp(input string tag, input logic [19:0] d);
        logic [19:0] e;
        @(negedge clk);
        disp_addr_in = d;
        #2;
        e = (m_ctl[4] && m_ctl[3]) ? d + {m_dsp, 4'h0} : d;
        checks++;
        if (disp_addr_out !== e) begin
            errors++;
            $display("FAIL %s actual disp=%h expected %h", tag, disp_addr_out, e);
        end
    endtask

    task automatic chk_dram(input string tag);
        #2;
        checks++;
        if (dram_cfg !== m_ctl[1:0]) begin
            errors++;
            $display("FAIL %s actual dram_cfg=%0d expected %0d", tag, dram_cfg, m_ctl[1:0]);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        acc("R1 reset hit", 20'hA1234, 1'b0);
        acc("R1 reset miss B", 20'hB0000, 1'b1);
        chk_dram("R1 reset dram");
        dsp("R1 reset disp", 20'h12345);

        // R2 locked writes ignored
        wr(8'h10, 8'h12);
        wr(8'h16, 8'h10);
        acc("R2 locked ctl", 20'hA0100, 1'b1);
        wr(8'h00, 8'h01);
        wr(8'h16, 8'h10);
        acc("R2 locked pri", 20'hA0100, 1'b1);

        // R3 memory-organisation guard
        wr(8'h16, 8'h13);
        chk_dram("R3 guarded");
        acc("R3 rest of write kept", 20'hA0200, 1'b0);
        wr(8'h00, 8'h03);
        wr(8'h16, 8'h12);
        chk_dram("R3 unlocked");

        // R5 misses
        acc("R5 below", 20'h9FFFF, 1'b0);
        acc("R5 above", 20'hC0000, 1'b1);
        acc("R5 B in 64K", 20'hB4000, 1'b0);

        // R7 R8 default mode
        wr(8'h10, 8'h10); wr(8'h11, 8'h00);
        wr(8'h12, 8'h20); wr(8'h13, 8'h00);
        wr(8'h16, 8'h14);
        acc("R8 write primary", 20'hA0010, 1'b1);
        acc("R8 read secondary", 20'hA0010, 1'b0);
        wr(8'h16, 8'h10);
        acc("R8 read primary", 20'hA0010, 1'b0);
        wr(8'h16, 8'h30);
        acc("R8 mode1 write", 20'hAFFFF, 1'b1);
        wr(8'h10, 8'hFF); wr(8'h11, 8'hFF);
        acc("R7 wrap", 20'hA0020, 1'b1);

        // R9 mode 3
        wr(8'h16, 8'h70);
        acc("R9 write secondary", 20'hA0040, 1'b1);
        acc("R9 read secondary", 20'hA0040, 1'b0);

        // R10 mode 2
        wr(8'h16, 8'h50);
        acc("R10 B seg", 20'hB1234, 1'b1);
        acc("R10 A seg", 20'hA1234, 1'b0);
        acc("R10 top", 20'hBFFFF, 1'b0);

        // R11 mode 6
        wr(8'h16, 8'hD0);
        acc("R11 upper half", 20'hA8004, 1'b1);
        acc("R11 lower half", 20'hA7FFF, 1'b0);
        acc("R11 B miss", 20'hB0000, 1'b1);

        // R4 R6 window maps, no extended memory
        wr(8'h16, 8'h00);
        wr(8'h17, 8'h01);
        acc("R4 wide top", 20'hBFFFF, 1'b0);
        acc("R6 wide A", 20'hA0001, 1'b1);
        wr(8'h17, 8'h03);
        acc("R4 map1 no wide", 20'hB0000, 1'b0);
        wr(8'h17, 8'h04);
        acc("R4 map2 end", 20'hB7FFF, 1'b0);
        acc("R4 map2 miss", 20'hB8000, 1'b0);
        wr(8'h17, 8'h06);
        acc("R4 map3 start", 20'hB8000, 1'b1);
        acc("R4 map3 miss A", 20'hA0000, 1'b1);

        // R12 display relocation
        wr(8'h14, 8'h0A); wr(8'h15, 8'hBC);
        wr(8'h16, 8'h18);
        dsp("R12 relocated", 20'h12345);
        dsp("R12 wrap", 20'hFFFF0);
        wr(8'h16, 8'h08);
        dsp("R12 ext off", 20'h12345);

        // random mix of writes, host accesses and display fetches
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 4) == 0) begin
                logic [7:0] idx;
                case ($urandom % 10)
                    0: idx = 8'h00;
                    1: idx = 8'h20;
                    default: idx = 8'h10 + 8'($urandom % 8);
                endcase
                wr(idx, (idx == 8'h00) ? 8'($urandom % 8 == 0 ? 0 : 3) : 8'($urandom));
                chk_dram("R3 random");
            end
            acc("R7 random", 20'h98000 + 20'($urandom % 20'h30000), 1'($urandom));
            if ((i % 8) == 0) dsp("R12 random", 20'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule